// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog

This block is a system timer. It holds one 32-bit up-counter that advances on a one-cycle tick strobe from an external prescaler, and a small set of match channels, four by default. Each channel holds a 32-bit compare value. When the counter takes a new value equal to a channel's compare value, and that channel is enabled, the channel latches a sticky status bit. Each channel has its own interrupt line, and that line follows the status bit. Software handles the block through a plain word-offset register port with a single-cycle write strobe and a read strobe. The read strobe returns data one cycle later.

The highest channel also works as a watchdog. While the watchdog arm bit is set, a match on that channel issues a one-cycle system reset request and disarms the watchdog. Software must arm it again before it can fire a second time. Software can rewrite the counter at any moment. Counting resumes from the written value, and that value is compared against the channels straight away.

Top module: `ostm_timer`

## Requirements
- R1: After reset every software-visible register reads zero. The compare values sit at byte offsets 0x00, 0x04, 0x08 and 0x0C, the counter at 0x10, the status at 0x14, the watchdog arm at 0x18 and the channel enable at 0x1C. A write to a compare value reads back unchanged. Read data and the error flag appear on the cycle after the one with `reg_rd` high.
- R2: The counter increases by one on every cycle with `tick` high, holds otherwise, and rolls over from 0xFFFFFFFF to 0x00000000.
- R3: A write to offset 0x10 loads the counter and takes priority over a tick in the same cycle. The load counts as a counter update, so a compare value equal to the loaded value produces a match.
- R4: When a counter update makes the counter equal to compare value n and enable bit n is set, status bit n and `irq[n]` go high two clock edges after the update is sampled. Matches happen only on updates, so a counter that stays on the compare value matches just once. `irq[n]` always equals status bit n.
- R5: With enable bit n clear, a match on channel n leaves status bit n and `irq[n]` low.
- R6: A write to offset 0x14 clears only those status bits that are written as 1 and are currently set, and it lowers the matching interrupt lines. Other bits are untouched. A match that sets a bit in the same cycle wins over the clear.
- R7: The enable register at 0x1C keeps the low 12 bits of a write and drops the rest. Bits [3:0] enable channels 0 to 3.
- R8: With bit 0 of offset 0x18 set, a match on channel 3 pulses `sys_reset_req` for exactly one cycle and clears the arm bit on the same edge, whatever the enable bit. A further match with the watchdog disarmed requests nothing.
- R9: A read of any other offset returns zero and pulses `reg_err` for one cycle. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe from the prescaler, one cycle per count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| reg_err | output | 1 | One-cycle pulse for a read of an unmapped offset |
| irq | output | 4 | Per-channel interrupt lines |
| sys_reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The hardest cases to reach are the compare events that do not come from ordinary counting: a match produced by a software load, a match at the counter rollover, and the check that a counter parked on a compare value matches only once. The stimulus loads the counter just below or exactly on a compare value, and then holds the tick low for many cycles after clearing status. The watchdog one-shot is reached by arming it, counting onto channel 3 with that channel's interrupt disabled, and then counting onto it a second time. A behavioural model that runs beside the design catches any extra reset request or status bit in any cycle.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
  localparam int unsigned OFS_MATCH    = 'h00;
  localparam int unsigned MATCH_STRIDE = 4;
  localparam int unsigned OFS_COUNT    = 'h10;
  localparam int unsigned OFS_STATUS   = 'h14;
  localparam int unsigned OFS_WDOG     = 'h18;
  localparam int unsigned OFS_IEN      = 'h1C;
endpackage

// File: rtl/ostm_counter.sv
module ostm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         upd
);
  // a load outranks a tick in the same cycle
  assign upd     = load | tick;
  assign cnt_nxt = load ? load_val : cnt_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (upd) cnt_q <= cnt_nxt;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> cnt_q == $past(cnt_q) + W'(1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
  assert_count_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/ostm_match.sv
module ostm_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  input  logic [W-1:0] cnt_nxt,
  output logic [W-1:0] match_q,
  output logic         hit_q
);
  // compare the value the counter is about to take, so the hit is
  // registered on the same edge the counter changes
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (wr) match_q <= wdata;
      hit_q <= upd && (cnt_nxt == match_q);
    end
  end

  assert_hit_on_update_R4: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(upd));
endmodule

// File: rtl/ostm_regs.sv
module ostm_regs
  import ostm_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NCH     = 4,
  parameter int IEN_W   = 12,
  parameter int AW      = 8,
  parameter int WDOG_CH = NCH - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [AW-1:0]           reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  input  logic [NCH-1:0]          hit,
  input  logic [NCH-1:0][DW-1:0]  match_vals,
  input  logic [DW-1:0]           cnt,
  output logic [NCH-1:0]          irq,
  output logic                    sys_reset_req,
  output logic [DW-1:0]           reg_rdata,
  output logic                    reg_err
);
  logic [NCH-1:0]   status_q;
  logic [IEN_W-1:0] ien_q;
  logic             wden_q;
  logic             req_q;
  logic [NCH-1:0]   set_v, clr_v;
  logic             wr_stat, wr_ien, wr_wd, fire;
  logic [DW-1:0]    rd_val;
  logic             rd_bad;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STATUS));
  assign wr_ien  = reg_wr && (reg_addr == AW'(OFS_IEN));
  assign wr_wd   = reg_wr && (reg_addr == AW'(OFS_WDOG));

  assign set_v = hit & ien_q[NCH-1:0];
  assign clr_v = wr_stat ? (reg_wdata[NCH-1:0] & status_q) : '0;
  assign fire  = hit[WDOG_CH] & wden_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ien_q    <= '0;
      wden_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_ien) ien_q <= reg_wdata[IEN_W-1:0];
      if (fire)       wden_q <= 1'b0;
      else if (wr_wd) wden_q <= reg_wdata[0];
      req_q <= fire;
    end
  end

  assign irq           = status_q;
  assign sys_reset_req = req_q;

  always_comb begin
    rd_val = '0;
    rd_bad = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(OFS_MATCH + MATCH_STRIDE * i)) begin
        rd_val = match_vals[i];
        rd_bad = 1'b0;
      end
    end
    if (reg_addr == AW'(OFS_COUNT)) begin
      rd_val = cnt;
      rd_bad = 1'b0;
    end
    if (reg_addr == AW'(OFS_STATUS)) begin
      rd_val = DW'(status_q);
      rd_bad = 1'b0;
    end
    if (reg_addr == AW'(OFS_WDOG)) begin
      rd_val = DW'(wden_q);
      rd_bad = 1'b0;
    end
    if (reg_addr == AW'(OFS_IEN)) begin
      rd_val = DW'(ien_q);
      rd_bad = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_rdata <= reg_rd ? (rd_bad ? '0 : rd_val) : '0;
      reg_err   <= reg_rd && rd_bad;
    end
  end

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq)) & ~$past(ien_q[NCH-1:0])) == '0);
  assert_clear_only_written_R6: assert property (@(posedge clk) disable iff (rst)
    (($past(irq) & ~irq) & ~($past(wr_stat) ? $past(reg_wdata[NCH-1:0]) : '0)) == '0);
  assert_ien_keeps_low_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ien |=> ien_q == $past(reg_wdata[IEN_W-1:0]));
  assert_wdog_oneshot_R8: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> (!wden_q && $past(wden_q)));
  assert_wdog_fires_R8: assert property (@(posedge clk) disable iff (rst)
    (hit[WDOG_CH] && wden_q) |=> sys_reset_req);
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> ($past(reg_rd) && reg_rdata == '0));
endmodule

// File: rtl/ostm_timer.sv
module ostm_timer
  import ostm_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NCH     = 4,
  parameter int IEN_W   = 12,
  parameter int AW      = 8,
  parameter int WDOG_CH = NCH - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_err,
  output logic [NCH-1:0] irq,
  output logic           sys_reset_req
);
  logic [DW-1:0]           cnt_q, cnt_nxt;
  logic                    upd, load;
  logic [NCH-1:0]          hit, m_wr;
  logic [NCH-1:0][DW-1:0]  match_vals;

  assign load = reg_wr && (reg_addr == AW'(OFS_COUNT));

  ostm_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(reg_wdata),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .upd(upd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign m_wr[g] = reg_wr && (reg_addr == AW'(OFS_MATCH + MATCH_STRIDE * g));
    ostm_match #(.W(DW)) u_match (
      .clk(clk), .rst(rst), .wr(m_wr[g]), .wdata(reg_wdata),
      .upd(upd), .cnt_nxt(cnt_nxt),
      .match_q(match_vals[g]), .hit_q(hit[g])
    );
  end

  ostm_regs #(
    .DW(DW), .NCH(NCH), .IEN_W(IEN_W), .AW(AW), .WDOG_CH(WDOG_CH)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hit(hit),
    .match_vals(match_vals), .cnt(cnt_q), .irq(irq),
    .sys_reset_req(sys_reset_req), .reg_rdata(reg_rdata), .reg_err(reg_err)
  );
endmodule

// File: tb/tb_ostm_timer.sv
`timescale 1ns/1ps
module tb_ostm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic [3:0]  irq;
  logic        sys_reset_req;

  always #2 clk = ~clk;

  ostm_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .irq(irq), .sys_reset_req(sys_reset_req)
  );

  int checks = 0;
  int fails  = 0;
  int req_seen = 0;
  bit done = 0;

  // behavioural reference model
  logic [31:0] m_cnt, m_rdata;
  logic [31:0] m_match [4];
  logic [11:0] m_ien;
  logic [3:0]  m_stat, m_hit;
  logic        m_wden, m_req, m_err, m_rv;

  always @(posedge clk) begin
    logic [31:0] nxt;
    logic [3:0]  set_b, clr_b, new_hit;
    logic        fire, upd, ok;
    if (rst) begin
      m_cnt = 0; m_ien = 0; m_stat = 0; m_hit = 0; m_wden = 0; m_req = 0;
      m_rdata = 0; m_err = 0; m_rv = 0;
      for (int i = 0; i < 4; i++) m_match[i] = 0;
    end else begin
      // read uses pre-edge state
      m_rv = reg_rd; m_rdata = 0; m_err = 0; ok = 0;
      if (reg_rd) begin
        for (int i = 0; i < 4; i++)
          if (reg_addr == 8'(4 * i)) begin m_rdata = m_match[i]; ok = 1; end
        if (reg_addr == 8'h10) begin m_rdata = m_cnt; ok = 1; end
        if (reg_addr == 8'h14) begin m_rdata = {28'd0, m_stat}; ok = 1; end
        if (reg_addr == 8'h18) begin m_rdata = {31'd0, m_wden}; ok = 1; end
        if (reg_addr == 8'h1C) begin m_rdata = {20'd0, m_ien}; ok = 1; end
        m_err = !ok;
      end
      set_b = m_hit & m_ien[3:0];
      clr_b = (reg_wr && reg_addr == 8'h14) ? (reg_wdata[3:0] & m_stat) : 4'd0;
      fire  = m_hit[3] && m_wden;
      upd   = tick || (reg_wr && reg_addr == 8'h10);
      nxt   = (reg_wr && reg_addr == 8'h10) ? reg_wdata : m_cnt + 1;
      for (int i = 0; i < 4; i++) new_hit[i] = upd && (nxt == m_match[i]);
      m_stat = (m_stat & ~clr_b) | set_b;
      m_req  = fire;
      if (fire) m_wden = 0;
      else if (reg_wr && reg_addr == 8'h18) m_wden = reg_wdata[0];
      if (reg_wr && reg_addr == 8'h1C) m_ien = reg_wdata[11:0];
      for (int i = 0; i < 4; i++)
        if (reg_wr && reg_addr == 8'(4 * i)) m_match[i] = reg_wdata;
      if (upd) m_cnt = nxt;
      m_hit = new_hit;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sys_reset_req) req_seen++;
      checks++;
      if (irq !== m_stat) begin
        fails++;
        $display("FAIL R4/R6 irq act=%h exp=%h at %0t", irq, m_stat, $time);
      end
      checks++;
      if (sys_reset_req !== m_req) begin
        fails++;
        $display("FAIL R8 sys_reset_req act=%b exp=%b at %0t", sys_reset_req, m_req, $time);
      end
      if (m_rv) begin
        checks++;
        if (reg_rdata !== m_rdata || reg_err !== m_err) begin
          fails++;
          $display("FAIL R1/R9 read act=%h/%b exp=%h/%b at %0t",
                   reg_rdata, reg_err, m_rdata, m_err, $time);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; tick = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; tick = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; e = reg_err;
    reg_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(4 * a), d, e);
      check("R1 reset value", d, 0);
    end
    // R7 enable keeps low 12 bits
    wr(8'h1C, 32'hABCDE5A5);
    rd(8'h1C, d, e);
    check("R7 enable mask", d, 32'h5A5);
    wr(8'h1C, 32'h3);
    // R1 compare readback
    wr(8'h00, 32'd5); wr(8'h04, 32'd7); wr(8'h08, 32'h100); wr(8'h0C, 32'hFFFF0000);
    rd(8'h04, d, e); check("R1 match1 readback", d, 7);
    rd(8'h0C, d, e); check("R1 match3 readback", d, 32'hFFFF0000);
    // R4 match via counting
    ticks(5); idle(2);
    check("R4 irq0 after count to 5", {28'd0, irq}, 1);
    rd(8'h10, d, e); check("R2 counter value", d, 5);
    ticks(2); idle(2);
    check("R4 irq1 after count to 7", {28'd0, irq}, 3);
    // R6 clear semantics
    wr(8'h14, 32'hC); idle(1);
    check("R6 clear of unset bits", {28'd0, irq}, 3);
    wr(8'h14, 32'h1); idle(1);
    check("R6 clear bit0", {28'd0, irq}, 2);
    rd(8'h14, d, e); check("R6 status read", d, 2);
    wr(8'h14, 32'h2); idle(1);
    // R3 load onto compare value
    wr(8'h10, 32'd7); idle(2);
    check("R3 load matches", {28'd0, irq}, 2);
    wr(8'h14, 32'h2); idle(10);
    check("R4 single match while parked", {28'd0, irq}, 0);
    rd(8'h10, d, e); check("R3 loaded counter", d, 7);
    // R5 disabled channel
    wr(8'h10, 32'hFF); ticks(1); idle(2);
    check("R5 disabled channel irq", {28'd0, irq}, 0);
    rd(8'h14, d, e); check("R5 disabled channel status", d, 0);
    // R2 rollover
    wr(8'h00, 32'd0); wr(8'h10, 32'hFFFFFFFE); ticks(2); idle(2);
    check("R2 rollover match", {28'd0, irq}, 1);
    rd(8'h10, d, e); check("R2 rollover value", d, 0);
    wr(8'h14, 32'h1);
    // R8 watchdog
    wr(8'h0C, 32'h50); wr(8'h18, 32'h1);
    rd(8'h18, d, e); check("R8 armed", d, 1);
    wr(8'h10, 32'h4E); ticks(2); idle(2);
    check("R8 one reset request", req_seen, 1);
    rd(8'h18, d, e); check("R8 disarmed", d, 0);
    check("R8 channel3 irq stays low", {28'd0, irq}, 0);
    wr(8'h10, 32'h4F); ticks(1); idle(3);
    check("R8 no request when disarmed", req_seen, 1);
    // R9 unmapped access
    rd(8'h20, d, e);
    check("R9 unmapped data", d, 0); check("R9 unmapped err", {31'd0, e}, 1);
    rd(8'h06, d, e);
    check("R9 misaligned err", {31'd0, e}, 1);
    wr(8'h24, 32'hFFFFFFFF);
    rd(8'h1C, d, e); check("R9 write ignored", d, 3);
    check("R9 no err on mapped read", {31'd0, e}, 0);
    // R3 load beats tick
    wr_tick(8'h10, 32'h10);
    rd(8'h10, d, e); check("R3 load over tick", d, 32'h10);
    idle(4);
    finish_run();
  end
endmodule